// File: doc/BRIEF.md
# Folded Symmetric FIR Filter

This block is a streaming low-pass FIR filter whose impulse response is mirror-symmetric. It keeps a line of the most recent accepted samples. Before any multiplication, it sums each pair of taps that share a weight, so a filter of `NTAPS` taps needs only `NTAPS/2` multipliers. The weights are not built in. They arrive on a run-time input bus, so the same hardware serves any symmetric response.

A sample is offered with `in_valid`. It passes through one input register stage, then the arithmetic, then one output register stage. Alongside the filtered result, the block returns the oldest sample in the line as it stood before the update, which is the input delayed by `NTAPS` accepted samples. All values are two's-complement fixed point. The result is rounded and then saturated back to the sample width.

Top module: `sfir_folded`

## Requirements
- R1: While `rst` is high, the block clears all tap registers, `y_out`, `xd_out` and `out_valid` to zero.
- R2: A cycle with `in_valid` low is ignored. The tap line, `y_out` and `xd_out` keep their values, and no output cycle is flagged for it.
- R3: Each accepted sample enters the newest tap. Every tap moves one place toward the oldest, and the oldest value drops out.
- R4: Tap k (k = 1 newest .. NTAPS oldest) is pre-added with tap NTAPS+1-k. The pair sum for k = 1..NTAPS/2 is multiplied by coefficient k, carried in bits [k*CW-1 : (k-1)*CW] of `coef_in`. So the outermost pair uses the lowest slot.
- R5: A result is formed from the tap contents as they were before that sample's shift. The sample that triggers the result does not contribute to it.
- R6: `xd_out` returns the oldest tap read before the shift. This is the sample accepted `NTAPS` accepted samples earlier, or zero while the line is still filling after reset.
- R7: `out_valid` is high in the cycle two clock edges after a cycle with `in_valid` high, and low two edges after a cycle with `in_valid` low.
- R8: Samples and coefficients are 14-bit two's complement with 13 fraction bits. `y_out` is the exact sum of the products, divided by 2^13 and rounded half toward positive infinity.
- R9: A rounded result above 8191 is output as 8191. A rounded result below -8192 is output as -8192.
- R10: Coefficients are captured together with each accepted sample. Values on `coef_in` during cycles with `in_valid` low have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `x_in` and `coef_in` this cycle |
| x_in | input | DW (14) | Input sample, signed |
| coef_in | input | NTAPS/2*CW (56) | Packed signed coefficients, outermost pair in the low slot |
| out_valid | output | 1 | A new result is present on `y_out`/`xd_out` |
| y_out | output | DW (14) | Filtered sample, rounded and saturated |
| xd_out | output | DW (14) | Input sample delayed by NTAPS accepted samples |

## Verification
The bench builds the filter with its default parameters: 14-bit samples and weights, 13 fraction bits and 8 taps, giving four folded pairs. With this width the bench can drive full-scale constant data together with full-scale weights, which pushes the wide sum far past the 14-bit range in both directions and exercises both saturation limits. An 8-deep line is short enough that an impulse can be followed through every pairing and out through the delayed-sample port within a few cycles. Idle gaps carrying garbage weights then show that only the weights captured with a sample are used.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
    // Default word geometry of the folded filter
    localparam int SFIR_DATA_W    = 14;
    localparam int SFIR_COEF_W    = 14;
    localparam int SFIR_COEF_FRAC = 13;
    localparam int SFIR_TAPS      = 8;
endpackage

// File: rtl/sfir_tapline.sv
module sfir_tapline #(
    parameter int DW    = 14,
    parameter int NTAPS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] taps [NTAPS]
);
    // Sample line: index 0 is the newest entry
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
        end else if (shift_en) begin
            taps[0] <= din;
            for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
        end
    end

    assert_clear_R1: assert property (@(posedge clk)
        rst |=> (taps[0] == '0 && taps[NTAPS-1] == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> ($stable(taps[0]) && $stable(taps[NTAPS-1])));

    assert_shift_R3: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (taps[NTAPS-1] == $past(taps[NTAPS-2])));
endmodule

// File: rtl/sfir_fold_mac.sv
module sfir_fold_mac #(
    parameter int DW    = 14,
    parameter int CW    = 14,
    parameter int NTAPS = 8,
    localparam int NPAIR = NTAPS / 2,
    localparam int PW    = DW + 1,
    localparam int MW    = PW + CW,
    localparam int AW    = MW + $clog2(NPAIR)
) (
    input  logic signed [DW-1:0] taps  [NTAPS],
    input  logic signed [CW-1:0] coefs [NPAIR],
    output logic signed [AW-1:0] acc
);
    logic signed [PW-1:0] pre  [NPAIR];
    logic signed [MW-1:0] prod [NPAIR];

    // Mirrored taps share a weight: add first, multiply once
    always_comb begin
        acc = '0;
        for (int k = 0; k < NPAIR; k++) begin
            pre[k]  = PW'(taps[k]) + PW'(taps[NTAPS-1-k]);
            prod[k] = MW'(pre[k]) * MW'(coefs[k]);
            acc     = acc + AW'(prod[k]);
        end
    end
endmodule

// File: rtl/sfir_round_sat.sv
module sfir_round_sat #(
    parameter int AW   = 31,
    parameter int OW   = 14,
    parameter int FRAC = 13
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [OW-1:0] y
);
    localparam logic signed [AW:0] HALF = {{(AW-FRAC+1){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [AW:0] MAXV = {{(AW-OW+2){1'b0}}, {(OW-1){1'b1}}};
    localparam logic signed [AW:0] MINV = {{(AW-OW+2){1'b1}}, {(OW-1){1'b0}}};

    logic signed [AW:0] rnd;
    logic signed [AW:0] shf;

    always_comb begin
        rnd = {acc[AW-1], acc} + HALF;
        shf = rnd >>> FRAC;
        if (shf > MAXV)      y = MAXV[OW-1:0];
        else if (shf < MINV) y = MINV[OW-1:0];
        else                 y = shf[OW-1:0];
    end
endmodule

// File: rtl/sfir_folded.sv
module sfir_folded
    import sfir_pkg::*;
#(
    parameter int DW    = SFIR_DATA_W,
    parameter int CW    = SFIR_COEF_W,
    parameter int FRAC  = SFIR_COEF_FRAC,
    parameter int NTAPS = SFIR_TAPS,
    localparam int NPAIR = NTAPS / 2,
    localparam int AW    = DW + 1 + CW + $clog2(NPAIR)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [DW-1:0]    x_in,
    input  logic [NPAIR*CW-1:0]     coef_in,
    output logic                    out_valid,
    output logic signed [DW-1:0]    y_out,
    output logic signed [DW-1:0]    xd_out
);
    // Input register stage
    logic                 vld_q;
    logic signed [DW-1:0] x_q;
    logic signed [CW-1:0] coef_q [NPAIR];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            x_q   <= '0;
            for (int k = 0; k < NPAIR; k++) coef_q[k] <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                x_q <= x_in;
                for (int k = 0; k < NPAIR; k++) coef_q[k] <= coef_in[k*CW +: CW];
            end
        end
    end

    // Sample line, shifted once per accepted sample
    logic signed [DW-1:0] taps [NTAPS];

    sfir_tapline #(.DW(DW), .NTAPS(NTAPS)) u_line (
        .clk      (clk),
        .rst      (rst),
        .shift_en (vld_q),
        .din      (x_q),
        .taps     (taps)
    );

    // Folded multiply-accumulate on the pre-shift contents
    logic signed [AW-1:0] acc;

    sfir_fold_mac #(.DW(DW), .CW(CW), .NTAPS(NTAPS)) u_mac (
        .taps  (taps),
        .coefs (coef_q),
        .acc   (acc)
    );

    logic signed [DW-1:0] y_next;

    sfir_round_sat #(.AW(AW), .OW(DW), .FRAC(FRAC)) u_rs (
        .acc (acc),
        .y   (y_next)
    );

    // Output register stage
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            y_out     <= '0;
            xd_out    <= '0;
        end else begin
            out_valid <= vld_q;
            if (vld_q) begin
                y_out  <= y_next;
                xd_out <= taps[NTAPS-1];
            end
        end
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 ($stable(y_out) && $stable(xd_out)));
endmodule

// File: tb/sfir_folded_tb_top.sv
module sfir_folded_tb_top;
    localparam int DW = 14, CW = 14, FRAC = 13, NT = 8, NP = NT / 2;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] x_in = '0;
    logic [NP*CW-1:0]     coef_in = '0;
    logic                 out_valid;
    logic signed [DW-1:0] y_out, xd_out;

    sfir_folded dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in),
        .coef_in(coef_in), .out_valid(out_valid), .y_out(y_out), .xd_out(xd_out)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_cmp = 0, n_bad = 0;
    bit checking = 1'b0, done = 1'b0;
    int hist [NT];
    int coef_m [NP];
    int q_y[$], q_xd[$], q_due[$];
    int last_y = 0, last_xd = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    function automatic int pack_ok(input int v);
        return v;
    endfunction

    // Behavioural model: compute from history, then push the new sample
    task automatic send(input int x);
        longint acc;
        longint r;
        @(negedge clk);
        in_valid = 1'b1;
        x_in = DW'(x);
        for (int k = 0; k < NP; k++) coef_in[k*CW +: CW] = CW'(coef_m[k]);
        acc = 0;
        for (int k = 0; k < NP; k++)
            acc += longint'(coef_m[k]) * longint'(hist[k] + hist[NT-1-k]);
        r = (acc + (longint'(1) <<< (FRAC-1))) >>> FRAC;
        if (r > 8191) r = 8191;
        if (r < -8192) r = -8192;
        q_y.push_back(int'(r));
        q_xd.push_back(hist[NT-1]);
        q_due.push_back(cyc + 2);
        for (int i = NT-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
    endtask

    // Idle cycles with garbage on the data and weight inputs (R10, R2)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            x_in = DW'($urandom);
            coef_in = {$urandom, $urandom};
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (checking) begin
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                chk(out_valid == 1'b1, "R7 out_valid", int'(out_valid), 1);
                chk(int'(y_out) == q_y[0], "R4 R5 R8 R9 R10 y_out", int'(y_out), q_y[0]);
                chk(int'(xd_out) == q_xd[0], "R3 R6 xd_out", int'(xd_out), q_xd[0]);
                last_y = q_y[0];
                last_xd = q_xd[0];
                void'(q_y.pop_front());
                void'(q_xd.pop_front());
                void'(q_due.pop_front());
            end else begin
                chk(out_valid == 1'b0, "R7 out_valid idle", int'(out_valid), 0);
                chk(int'(y_out) == last_y && int'(xd_out) == last_xd,
                    "R2 hold y_out", int'(y_out), last_y);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        report();
    end

    initial begin
        for (int i = 0; i < NT; i++) hist[i] = 0;
        // Typical low-pass weights in Q1.13, outermost pair first (R4)
        coef_m[0] = -1097; coef_m[1] = -686; coef_m[2] = 1660; coef_m[3] = 3329;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        chk(y_out == '0, "R1 reset y_out", int'(y_out), 0);
        chk(xd_out == '0, "R1 reset xd_out", int'(xd_out), 0);
        checking = 1'b1;

        // Impulse: walks through every pair and out the delayed port
        send(8191);
        for (int i = 0; i < 10; i++) send(0);
        // Step
        for (int i = 0; i < 12; i++) send(4096);
        // Gapped stream with junk weights during the gaps (R10)
        for (int i = 0; i < 10; i++) begin
            send((i % 2 == 0) ? 3000 : -2500);
            idle(2);
        end
        // Full-scale alternating input
        for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 8191 : -8192);
        // Positive saturation (R9)
        for (int k = 0; k < NP; k++) coef_m[k] = 8191;
        for (int i = 0; i < 10; i++) send(8191);
        // Negative saturation (R9)
        for (int i = 0; i < 10; i++) send(-8192);
        // Negative weights times negative data
        for (int k = 0; k < NP; k++) coef_m[k] = -8192;
        for (int i = 0; i < 10; i++) send(-8192);
        // Random samples and weights, with occasional gaps
        for (int i = 0; i < 60; i++) begin
            for (int k = 0; k < NP; k++) coef_m[k] = int'($urandom_range(16383)) - 8192;
            send(int'($urandom_range(16383)) - 8192);
            if (i % 7 == 3) idle(1);
        end
        idle(5);
        chk(q_due.size() == 0, "R7 all results delivered", q_due.size(), pack_ok(0));
        report();
    end
endmodule